// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block is the host-side front end of a floppy disk controller. A host processor reaches four byte-wide locations through an active-low select, a read/write line and a two-bit address. Location 0 is split by direction: a read returns the status byte and a write issues a command. Locations 1, 2 and 3 hold the track number, the sector number and the data byte, and each can be read back.

Behind the registers sits a small command sequencer. It steps the head one track in or out, or seeks until the track register matches the data register. It drives a step pulse of fixed width and a direction level. For read and write transfers it turns the spindle motor on and waits for the drive to report ready. For a write it raises the write gate a fixed lead time before it first asks for data. Two flags tell the host when to act. DRQ means the data register holds a new byte, or wants one. INTRQ means a command has finished.

Bit-level encoding, data separation and serialisation are handled outside this block. Received bytes arrive here as a parallel byte with a one-cycle valid. Bytes to be written leave the same way.

Top module: `fdc_host_regs`

## Requirements
- R1: A host access happens on every rising clock edge at which `cs_n` is low. With `rw`=1 the addressed location is copied to `rdata` at that edge, using the value it held before the edge. With `rw`=0, `wdata` is stored. Address 1 is the track register, 2 is the sector register and 3 is the data register.
- R2: While `rst` is high, all registers, `rdata`, `drq`, `intrq`, `motor_on`, `step`, `dir`, `wgate` and `wr_byte_vld` are driven to zero.
- R3: A write to address 0 issues a command, selected by the upper four data bits. The codes are 0x1 step in, 0x2 step out, 0x3 seek, 0x8 read and 0xA write. Any other code finishes at once without any drive activity. A read of address 0 returns status with bit 0 = busy, bit 1 = DRQ, bit 6 = write-protect flag, bit 7 = motor on, and all other bits 0. Busy is set when a command is accepted and cleared when it finishes.
- R4: INTRQ is set when a command finishes and cleared by a status read. If a status read and a completion land on the same edge, the set wins, and the read returns busy=1.
- R5: While busy, writes to address 0, to the track register and to the sector register are ignored.
- R6: Step in and step out each give one `step` pulse exactly STEP_HI clocks wide. `dir` is 1 for inward steps and 0 for outward steps, and it is stable for the whole pulse. The track register moves by +1 (inward) or -1 (outward).
- R7: Seek pulses until the track register equals the data register, moving inward if the target is higher. Consecutive pulses are separated by exactly SETTLE low clocks. If the two registers are already equal, seek finishes with no pulse.
- R8: A read or write command raises `motor_on` when it is accepted. The transfer does not start while `ready_n` is high. `motor_on` falls when the command finishes.
- R9: `wprot_n` is sampled only when a write command is accepted, and status bit 6 holds the inverse of that sample until the next write command. If the sample is low, the write finishes at once with no motor, no write gate and no data request.
- R10: During a write, `wgate` rises after ready and is high for at least GATE_LEAD clocks before DRQ first rises. Each host write to the data register during the transfer appears on `wr_byte` with a one-cycle `wr_byte_vld`. After XFER_BYTES bytes the command finishes and `wgate` falls. Outside a write transfer, data-register writes produce no `wr_byte_vld`.
- R11: During a read transfer, each `rd_byte_vld` loads `rd_byte` into the data register and sets DRQ. The command finishes after XFER_BYTES bytes. Outside a read transfer, `rd_byte_vld` is ignored.
- R12: A host read or write of the data register clears DRQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host select, active low |
| rw | input | 1 | 1 = host read, 0 = host write |
| addr | input | 2 | Register address |
| wdata | input | DW | Host write data |
| rdata | output | DW | Registered host read data |
| drq | output | 1 | Data register full (read) or empty (write) |
| intrq | output | 1 | Command finished |
| ready_n | input | 1 | Drive ready, active low |
| wprot_n | input | 1 | Media write protected, active low |
| motor_on | output | 1 | Spindle motor enable |
| step | output | 1 | Head step pulse |
| dir | output | 1 | Step direction, 1 = inward |
| wgate | output | 1 | Write gate |
| rd_byte | input | DW | Byte from the data separator |
| rd_byte_vld | input | 1 | Valid for `rd_byte` |
| wr_byte | output | DW | Byte to the serialiser |
| wr_byte_vld | output | 1 | Valid for `wr_byte` |

## Verification
A status read and the end of a command can fall on the same clock edge: one wants to clear INTRQ and the other wants to set it. The bench provokes this by writing a code that finishes at once, then reading status on the very next edge with `cs_n` held low. The read must return busy=1 and INTRQ must stay high. A second, separate status read must then return busy=0 and clear INTRQ.

// File: rtl/fdc_pkg.sv
`timescale 1ns/1ps
package fdc_pkg;
  localparam logic [1:0] ADR_CMD    = 2'd0;
  localparam logic [1:0] ADR_TRACK  = 2'd1;
  localparam logic [1:0] ADR_SECTOR = 2'd2;
  localparam logic [1:0] ADR_DATA   = 2'd3;

  localparam logic [3:0] OP_STEP_IN  = 4'h1;
  localparam logic [3:0] OP_STEP_OUT = 4'h2;
  localparam logic [3:0] OP_SEEK     = 4'h3;
  localparam logic [3:0] OP_READ     = 4'h8;
  localparam logic [3:0] OP_WRITE    = 4'hA;

  localparam int ST_BUSY  = 0;
  localparam int ST_DRQ   = 1;
  localparam int ST_WP    = 6;
  localparam int ST_MOTOR = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_SETTLE, S_SPIN, S_GATE, S_XFER, S_DONE
  } seq_state_e;
endpackage

// File: rtl/fdc_regs.sv
`timescale 1ns/1ps
module fdc_regs
  import fdc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rw,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          drq,
  output logic          intrq,
  input  logic          wprot_n,
  input  logic [DW-1:0] rd_byte,
  output logic [DW-1:0] wr_byte,
  output logic          wr_byte_vld,
  // sequencer side
  input  logic          done,
  input  logic          trk_up,
  input  logic          trk_dn,
  input  logic          drq_req,
  input  logic          rd_load,
  input  logic          wr_accept,
  input  logic          motor_on,
  output logic          cmd_go,
  output logic [3:0]    cmd_code,
  output logic          dwr,
  output logic [DW-1:0] track,
  output logic [DW-1:0] dreg
);
  logic          acc_rd, acc_wr, drd, stat_rd;
  logic          busy, wp_flag;
  logic [DW-1:0] sector, status;

  assign acc_rd   = !cs_n && rw;
  assign acc_wr   = !cs_n && !rw;
  assign stat_rd  = acc_rd && (addr == ADR_CMD);
  assign drd      = acc_rd && (addr == ADR_DATA);
  assign dwr      = acc_wr && (addr == ADR_DATA);
  assign cmd_go   = acc_wr && (addr == ADR_CMD) && !busy;
  assign cmd_code = wdata[DW-1 -: 4];

  always_comb begin
    status            = '0;
    status[ST_BUSY]   = busy;
    status[ST_DRQ]    = drq;
    status[ST_WP]     = wp_flag;
    status[ST_MOTOR]  = motor_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      intrq       <= 1'b0;
      drq         <= 1'b0;
      wp_flag     <= 1'b0;
      track       <= '0;
      sector      <= '0;
      dreg        <= '0;
      rdata       <= '0;
      wr_byte     <= '0;
      wr_byte_vld <= 1'b0;
    end else begin
      if (done)        busy <= 1'b0;
      else if (cmd_go) busy <= 1'b1;

      // completion beats a simultaneous status read
      if (done)         intrq <= 1'b1;
      else if (stat_rd) intrq <= 1'b0;

      if (cmd_go && cmd_code == OP_WRITE) wp_flag <= !wprot_n;

      if (rd_load)  dreg <= rd_byte;
      else if (dwr) dreg <= wdata;

      if (rd_load || drq_req) drq <= 1'b1;
      else if (drd || dwr)    drq <= 1'b0;

      if (trk_up)      track <= track + DW'(1);
      else if (trk_dn) track <= track - DW'(1);
      else if (acc_wr && addr == ADR_TRACK && !busy) track <= wdata;

      if (acc_wr && addr == ADR_SECTOR && !busy) sector <= wdata;

      if (acc_rd) begin
        case (addr)
          ADR_CMD:    rdata <= status;
          ADR_TRACK:  rdata <= track;
          ADR_SECTOR: rdata <= sector;
          default:    rdata <= dreg;
        endcase
      end

      wr_byte_vld <= dwr && wr_accept;
      if (dwr && wr_accept) wr_byte <= wdata;
    end
  end

  // R4: finishing a command raises the interrupt on the next cycle
  p_intrq_on_done_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> intrq);
  // R4: a status read without a coincident completion drops the interrupt
  p_intrq_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !done) |=> !intrq);
  // R5: sector writes during a command leave the register untouched
  p_sector_locked_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && acc_wr && addr == ADR_SECTOR) |=> $stable(sector));
  // R12: host access to the data register drops the request
  p_drq_clear_r12: assert property (@(posedge clk) disable iff (rst)
    ((drd || dwr) && !rd_load && !drq_req) |=> !drq);
  // R6: an inward step advances the track by exactly one
  p_track_up_r6: assert property (@(posedge clk) disable iff (rst)
    trk_up |=> (track == $past(track) + DW'(1)));
endmodule

// File: rtl/fdc_seq.sv
`timescale 1ns/1ps
module fdc_seq
  import fdc_pkg::*;
#(
  parameter int DW         = 8,
  parameter int STEP_HI    = 4,
  parameter int SETTLE     = 6,
  parameter int GATE_LEAD  = 3,
  parameter int XFER_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_go,
  input  logic [3:0]    cmd_code,
  input  logic          wprot_n,
  input  logic          ready_n,
  input  logic [DW-1:0] track,
  input  logic [DW-1:0] dreg,
  input  logic          rd_byte_vld,
  input  logic          dwr,
  output logic          done,
  output logic          trk_up,
  output logic          trk_dn,
  output logic          drq_req,
  output logic          rd_load,
  output logic          wr_accept,
  output logic          motor_on,
  output logic          step,
  output logic          dir,
  output logic          wgate
);
  localparam int M1   = (STEP_HI > SETTLE) ? STEP_HI : SETTLE;
  localparam int MAXC = (M1 > GATE_LEAD) ? M1 : GATE_LEAD;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(XFER_BYTES + 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bcnt;
  logic          seek, is_wr;

  assign step      = (state == S_PULSE);
  assign trk_up    = (state == S_PULSE) && (cnt == '0) && dir;
  assign trk_dn    = (state == S_PULSE) && (cnt == '0) && !dir;
  assign done      = (state == S_DONE);
  assign rd_load   = (state == S_XFER) && !is_wr && rd_byte_vld;
  assign wr_accept = (state == S_XFER) && is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bcnt     <= '0;
      seek     <= 1'b0;
      is_wr    <= 1'b0;
      dir      <= 1'b0;
      motor_on <= 1'b0;
      wgate    <= 1'b0;
      drq_req  <= 1'b0;
    end else begin
      drq_req <= 1'b0;
      case (state)
        S_IDLE: if (cmd_go) begin
          cnt  <= '0;
          bcnt <= '0;
          case (cmd_code)
            OP_STEP_IN:  begin dir <= 1'b1; seek <= 1'b0; state <= S_PULSE; end
            OP_STEP_OUT: begin dir <= 1'b0; seek <= 1'b0; state <= S_PULSE; end
            OP_SEEK: begin
              seek <= 1'b1;
              if (dreg == track) state <= S_DONE;
              else begin
                dir   <= (dreg > track);
                state <= S_PULSE;
              end
            end
            OP_READ: begin
              is_wr    <= 1'b0;
              motor_on <= 1'b1;
              state    <= S_SPIN;
            end
            OP_WRITE: begin
              is_wr <= 1'b1;
              if (!wprot_n) state <= S_DONE;
              else begin
                motor_on <= 1'b1;
                state    <= S_SPIN;
              end
            end
            default: state <= S_DONE;
          endcase
        end
        S_PULSE: begin
          if (cnt == CW'(STEP_HI - 1)) begin
            cnt   <= '0;
            state <= S_SETTLE;
          end else cnt <= cnt + CW'(1);
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE - 1)) begin
            cnt   <= '0;
            state <= (seek && track != dreg) ? S_PULSE : S_DONE;
          end else cnt <= cnt + CW'(1);
        end
        S_SPIN: if (!ready_n) begin
          if (is_wr) begin
            wgate <= 1'b1;
            cnt   <= '0;
            state <= S_GATE;
          end else state <= S_XFER;
        end
        S_GATE: begin
          if (cnt == CW'(GATE_LEAD - 1)) begin
            drq_req <= 1'b1;
            state   <= S_XFER;
          end else cnt <= cnt + CW'(1);
        end
        S_XFER: begin
          if ((is_wr && dwr) || (!is_wr && rd_byte_vld)) begin
            if (bcnt == BW'(XFER_BYTES - 1)) state <= S_DONE;
            else begin
              bcnt    <= bcnt + BW'(1);
              drq_req <= is_wr;
            end
          end
        end
        default: begin
          motor_on <= 1'b0;
          wgate    <= 1'b0;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  // R6: direction never moves under a step pulse
  p_dir_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (step && $past(step)) |-> $stable(dir));
  // R10: the write gate is only open with the motor running
  p_gate_needs_motor_r10: assert property (@(posedge clk) disable iff (rst)
    wgate |-> motor_on);
  // R10: data is requested only once the gate is open
  p_req_under_gate_r10: assert property (@(posedge clk) disable iff (rst)
    drq_req |-> wgate);
  // R8: the motor is off after a command finishes
  p_motor_drop_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !motor_on);
endmodule

// File: rtl/fdc_host_regs.sv
`timescale 1ns/1ps
module fdc_host_regs #(
  parameter int DW         = 8,
  parameter int STEP_HI    = 4,
  parameter int SETTLE     = 6,
  parameter int GATE_LEAD  = 3,
  parameter int XFER_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rw,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          drq,
  output logic          intrq,
  input  logic          ready_n,
  input  logic          wprot_n,
  output logic          motor_on,
  output logic          step,
  output logic          dir,
  output logic          wgate,
  input  logic [DW-1:0] rd_byte,
  input  logic          rd_byte_vld,
  output logic [DW-1:0] wr_byte,
  output logic          wr_byte_vld
);
  logic          done, trk_up, trk_dn, drq_req, rd_load, wr_accept;
  logic          cmd_go, dwr;
  logic [3:0]    cmd_code;
  logic [DW-1:0] track, dreg;

  fdc_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .drq(drq), .intrq(intrq),
    .wprot_n(wprot_n), .rd_byte(rd_byte), .wr_byte(wr_byte),
    .wr_byte_vld(wr_byte_vld), .done(done), .trk_up(trk_up),
    .trk_dn(trk_dn), .drq_req(drq_req), .rd_load(rd_load),
    .wr_accept(wr_accept), .motor_on(motor_on), .cmd_go(cmd_go),
    .cmd_code(cmd_code), .dwr(dwr), .track(track), .dreg(dreg)
  );

  fdc_seq #(
    .DW(DW), .STEP_HI(STEP_HI), .SETTLE(SETTLE),
    .GATE_LEAD(GATE_LEAD), .XFER_BYTES(XFER_BYTES)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_code(cmd_code),
    .wprot_n(wprot_n), .ready_n(ready_n), .track(track), .dreg(dreg),
    .rd_byte_vld(rd_byte_vld), .dwr(dwr), .done(done), .trk_up(trk_up),
    .trk_dn(trk_dn), .drq_req(drq_req), .rd_load(rd_load),
    .wr_accept(wr_accept), .motor_on(motor_on), .step(step), .dir(dir),
    .wgate(wgate)
  );
endmodule

// File: tb/fdc_host_regs_bench.sv
`timescale 1ns/1ps
module fdc_host_regs_bench;
  localparam int STEP_HI = 4, SETTLE = 6, GATE_LEAD = 3, XFER_BYTES = 2;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, rw = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rd_byte = '0;
  logic rd_byte_vld = 1'b0, ready_n = 1'b1, wprot_n = 1'b1;
  logic [7:0] rdata, wr_byte;
  logic drq, intrq, motor_on, step, dir, wgate, wr_byte_vld;

  fdc_host_regs #(.DW(8), .STEP_HI(STEP_HI), .SETTLE(SETTLE),
    .GATE_LEAD(GATE_LEAD), .XFER_BYTES(XFER_BYTES)) u_fdc_host_regs (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drq(drq), .intrq(intrq), .ready_n(ready_n),
    .wprot_n(wprot_n), .motor_on(motor_on), .step(step), .dir(dir),
    .wgate(wgate), .rd_byte(rd_byte), .rd_byte_vld(rd_byte_vld),
    .wr_byte(wr_byte), .wr_byte_vld(wr_byte_vld));

  always #2.5 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [7:0] exp_rd[$];
  string      tag_rd[$];
  logic [7:0] exp_wr[$];
  logic [7:0] mon_e;
  string      mon_t;
  int hi = 0, lo = 0, pulses = 0, wmin = 999, wmax = 0, gmin = 999, gmax = 0;
  logic dir_rise = 1'b0, dir_bad = 1'b0, motor_seen = 1'b0, wgate_seen = 1'b0;
  logic drq_q = 1'b0, wg_q = 1'b0;
  int drq_rise = 0, wg_rise = 0, wr_seen = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // scoreboard monitor: read data and outgoing write bytes
  always @(negedge clk) begin
    if (!rst && !cs_n && rw) begin
      if (exp_rd.size() == 0) chk("R1 unexpected read", 1, 0);
      else begin
        mon_e = exp_rd.pop_front();
        mon_t = tag_rd.pop_front();
        chk(mon_t, {24'd0, rdata}, {24'd0, mon_e});
      end
    end
    if (!rst && wr_byte_vld) begin
      wr_seen++;
      if (exp_wr.size() == 0) chk("R10 unexpected wr_byte_vld", 1, 0);
      else begin
        mon_e = exp_wr.pop_front();
        chk("R10 wr_byte", {24'd0, wr_byte}, {24'd0, mon_e});
      end
    end
  end

  // step / gate / request observers
  always @(negedge clk) begin
    if (step) begin
      if (hi == 0) begin
        if (pulses > 0) begin
          if (lo < gmin) gmin = lo;
          if (lo > gmax) gmax = lo;
        end
        dir_rise = dir;
      end else if (dir != dir_rise) dir_bad = 1'b1;
      hi++;
      lo = 0;
    end else begin
      if (hi != 0) begin
        pulses++;
        if (hi < wmin) wmin = hi;
        if (hi > wmax) wmax = hi;
      end
      hi = 0;
      lo++;
    end
    if (motor_on) motor_seen = 1'b1;
    if (wgate) wgate_seen = 1'b1;
    if (drq && !drq_q) drq_rise = cyc;
    if (wgate && !wg_q) wg_rise = cyc;
    drq_q = drq;
    wg_q  = wgate;
  end

  task automatic clr_mon();
    pulses = 0; wmin = 999; wmax = 0; gmin = 999; gmax = 0;
    dir_bad = 1'b0; motor_seen = 1'b0; wgate_seen = 1'b0;
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cs_n = 1'b0; rw = 1'b0; addr = a; wdata = d;
    @(negedge clk); #1;
    cs_n = 1'b1; rw = 1'b1;
  endtask

  task automatic host_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); #1;
    cs_n = 1'b0; rw = 1'b1; addr = a;
    exp_rd.push_back(e); tag_rd.push_back(tag);
    @(negedge clk); #1;
    cs_n = 1'b1;
  endtask

  // write then read on the very next edge, select held low
  task automatic host_wr_rd(input logic [1:0] a1, input logic [7:0] d,
                            input logic [1:0] a2, input logic [7:0] e, input string tag);
    @(negedge clk); #1;
    cs_n = 1'b0; rw = 1'b0; addr = a1; wdata = d;
    @(negedge clk); #1;
    rw = 1'b1; addr = a2;
    exp_rd.push_back(e); tag_rd.push_back(tag);
    @(negedge clk); #1;
    cs_n = 1'b1;
  endtask

  task automatic wait_irq(input int lim, input string tag);
    for (int i = 0; i < lim && !intrq; i++) @(negedge clk);
    #1;
    chk(tag, {31'd0, intrq}, 1);
  endtask

  task automatic pulse_rd_byte(input logic [7:0] b);
    @(negedge clk); #1;
    rd_byte = b; rd_byte_vld = 1'b1;
    @(negedge clk); #1;
    rd_byte_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R2 reset state
    chk("R2 rdata", {24'd0, rdata}, 0);
    chk("R2 flags", {26'd0, drq, intrq, motor_on, step, wgate, wr_byte_vld}, 0);
    #1 rst = 1'b0;
    host_rd(2'd0, 8'h00, "R2 status after reset");
    host_rd(2'd1, 8'h00, "R2 track after reset");
    host_rd(2'd3, 8'h00, "R2 data after reset");

    // R1 register file
    host_wr(2'd1, 8'h05);
    host_wr(2'd2, 8'h09);
    host_wr(2'd3, 8'hA5);
    host_rd(2'd1, 8'h05, "R1 track readback");
    host_rd(2'd2, 8'h09, "R1 sector readback");
    host_rd(2'd3, 8'hA5, "R1 data readback");

    // R4 collision: completion and status read on one edge
    host_wr_rd(2'd0, 8'h00, 2'd0, 8'h01, "R4 collision status busy");
    #1 chk("R4 set wins over status read", {31'd0, intrq}, 1);
    host_rd(2'd0, 8'h00, "R3 status after no-op");
    chk("R4 cleared by status read", {31'd0, intrq}, 0);

    // R6 step in
    clr_mon();
    host_wr(2'd0, 8'h10);
    host_rd(2'd0, 8'h01, "R3 busy while stepping");
    wait_irq(100, "R6 step in finishes");
    chk("R6 one pulse", pulses, 1);
    chk("R6 pulse width", wmax, STEP_HI);
    chk("R6 dir inward", {31'd0, dir_rise}, 1);
    chk("R6 dir stable", {31'd0, dir_bad}, 0);
    host_rd(2'd1, 8'h06, "R6 track incremented");
    host_rd(2'd0, 8'h00, "R3 idle after step");

    // R6 step out
    clr_mon();
    host_wr(2'd0, 8'h20);
    wait_irq(100, "R6 step out finishes");
    chk("R6 one pulse out", pulses, 1);
    chk("R6 dir outward", {31'd0, dir_rise}, 0);
    host_rd(2'd1, 8'h05, "R6 track decremented");
    host_rd(2'd0, 8'h00, "R4 clear");

    // R7 seek upward, R5 writes while busy ignored
    host_wr(2'd3, 8'h08);
    clr_mon();
    host_wr(2'd0, 8'h30);
    host_wr(2'd0, 8'h20);
    host_wr(2'd1, 8'h77);
    host_wr(2'd2, 8'h55);
    wait_irq(300, "R7 seek up finishes");
    chk("R7 three pulses", pulses, 3);
    chk("R7 gap min", gmin, SETTLE);
    chk("R7 gap max", gmax, SETTLE);
    chk("R6 width min", wmin, STEP_HI);
    chk("R7 dir inward", {31'd0, dir_rise}, 1);
    host_rd(2'd1, 8'h08, "R5 R7 track at target");
    host_rd(2'd2, 8'h09, "R5 sector unchanged");
    host_rd(2'd0, 8'h00, "R4 clear");

    // R7 seek already there
    clr_mon();
    host_wr(2'd0, 8'h30);
    wait_irq(50, "R7 seek equal finishes");
    chk("R7 no pulse when equal", pulses, 0);
    host_rd(2'd0, 8'h00, "R4 clear");

    // R7 seek downward
    host_wr(2'd3, 8'h02);
    clr_mon();
    host_wr(2'd0, 8'h30);
    wait_irq(400, "R7 seek down finishes");
    chk("R7 six pulses", pulses, 6);
    chk("R7 dir outward", {31'd0, dir_rise}, 0);
    host_rd(2'd1, 8'h02, "R7 track down at target");
    host_rd(2'd0, 8'h00, "R4 clear");

    // R9 protected write
    wprot_n = 1'b0;
    clr_mon();
    host_wr(2'd0, 8'hA0);
    wait_irq(50, "R9 protected write finishes");
    chk("R9 no motor", {31'd0, motor_seen}, 0);
    chk("R9 no gate", {31'd0, wgate_seen}, 0);
    chk("R9 no drq", {31'd0, drq}, 0);
    host_rd(2'd0, 8'h40, "R9 status wp flag");
    wprot_n = 1'b1;

    // R11 ignored byte while idle
    pulse_rd_byte(8'hEE);
    chk("R11 idle byte no drq", {31'd0, drq}, 0);
    host_rd(2'd3, 8'h02, "R11 idle byte ignored");

    // R8 / R11 read command
    host_wr(2'd0, 8'h80);
    repeat (10) @(negedge clk);
    #1 chk("R8 motor on waiting ready", {31'd0, motor_on}, 1);
    chk("R8 no finish before ready", {31'd0, intrq}, 0);
    host_rd(2'd0, 8'hC1, "R8 R9 status while spinning");
    ready_n = 1'b0;
    repeat (3) @(negedge clk);
    pulse_rd_byte(8'h3C);
    chk("R11 drq after byte", {31'd0, drq}, 1);
    host_rd(2'd0, 8'hC3, "R3 status with drq");
    host_rd(2'd3, 8'h3C, "R11 first byte");
    chk("R12 drq cleared by read", {31'd0, drq}, 0);
    pulse_rd_byte(8'hC3);
    wait_irq(20, "R11 read finishes");
    chk("R8 motor off at finish", {31'd0, motor_on}, 0);
    host_rd(2'd3, 8'hC3, "R11 second byte");
    host_rd(2'd0, 8'h40, "R9 flag held across read");

    // R10 write command
    clr_mon();
    host_wr(2'd0, 8'hA0);
    for (int i = 0; i < 60 && !drq; i++) @(negedge clk);
    #1 chk("R10 drq for first byte", {31'd0, drq}, 1);
    chk("R10 gate lead", {31'd0, (drq_rise - wg_rise) >= GATE_LEAD}, 1);
    chk("R10 gate open", {31'd0, wgate}, 1);
    host_rd(2'd0, 8'h83, "R9 R10 status during write");
    exp_wr.push_back(8'h11);
    host_wr(2'd3, 8'h11);
    chk("R12 drq cleared by write", {31'd0, drq}, 0);
    for (int i = 0; i < 20 && !drq; i++) @(negedge clk);
    #1 chk("R10 drq for second byte", {31'd0, drq}, 1);
    exp_wr.push_back(8'h22);
    host_wr(2'd3, 8'h22);
    wait_irq(20, "R10 write finishes");
    chk("R10 gate closed", {31'd0, wgate}, 0);
    chk("R8 motor off after write", {31'd0, motor_on}, 0);
    chk("R10 two bytes out", wr_seen, 2);
    host_rd(2'd0, 8'h00, "R9 flag from unprotected write");

    // R10 idle data write is not forwarded
    host_wr(2'd3, 8'h5A);
    repeat (2) @(negedge clk);
    #1 chk("R10 idle write not forwarded", wr_seen, 2);
    host_rd(2'd3, 8'h5A, "R1 idle data write stored");
    repeat (3) @(negedge clk);
    chk("R1 reads all consumed", exp_rd.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule